// File: doc/BRIEF.md
# I2C Slave Bus Status Tracker

This block is the receive-side front end of an I2C target. It samples the raw SCL and SDA lines through a two-flop synchroniser and finds START and STOP conditions. It assembles bytes most-significant bit first and checks the first byte of each transfer against a programmable 7-bit or 10-bit own address. When the address matches, it pulls SDA low in the ninth clock of the byte as an acknowledge. Matched bytes go into a single receive buffer, which the host drains.

A small set of status outputs reports the bus condition seen most recently, whether the last byte moved was an address or data, and the direction bit of the last matching address. Two further flags ask the host to reload the address register in 10-bit mode and report a lost byte when the buffer was still full. A release-control input lets the host hold SCL low so that the master waits. An interrupt pulse marks each byte event, and in two of the four modes it also marks each START and STOP.

Top module: `i2c_slave_status`

## Requirements
- R1: `start_seen_o` and `stop_seen_o` show which condition came last (START: SDA falls while SCL is high; STOP: SDA rises while SCL is high). Detecting one condition clears the other flag. Both flags are 0 after reset and while `en_i` is 0.
- R2: In 7-bit mode, a first byte whose upper seven bits equal `own_addr_i[6:0]` is acknowledged: `sda_low_o` is 1 during the ninth SCL high phase. A first byte that does not match gets no acknowledge, and every later byte is ignored until the next START.
- R3: Each accepted byte is written to `rx_data_o` and sets `buf_full_o`. A one-cycle pulse on `rd_i` clears `buf_full_o`.
- R4: If a data byte of a write transfer arrives while `buf_full_o` is 1, the block sets `overflow_o`, leaves `rx_data_o` unchanged and does not acknowledge. `overflow_o` stays set until a pulse on `ov_clr_i`.
- R5: An address byte whose direction bit is 1 (read) never sets `overflow_o`, even when the buffer is full, and it is still acknowledged.
- R6: `data_addr_o` is 0 after an address byte is accepted and 1 after a data byte is accepted.
- R7: `rw_o` takes bit 0 of a matching first address byte. It is cleared by a START, by a STOP, or by the master leaving SDA high in the ninth clock of a read byte.
- R8: Mode bit 0 set selects 10-bit mode. A first byte of the form `11110`,`own_addr_i[9:8]`,0 is acknowledged and followed by a byte that must equal `own_addr_i[7:0]`. Each accepted address byte in this mode sets `upd_addr_o`, and a pulse on `addr_load_i` clears it. A second byte that does not match is not acknowledged. A first byte `11110`,`own_addr_i[9:8]`,1 is acknowledged only after a full 10-bit match with no STOP since.
- R9: `scl_hold_low_o` is 1 exactly while `en_i` is 1 and `clk_release_i` is 0.
- R10: `irq_o` pulses for one cycle on every byte accepted or lost to overflow. It also pulses on START and STOP only when mode bit 1 is set. The modes are 00 = 7-bit, 01 = 10-bit, 10 = 7-bit with condition events, 11 = 10-bit with condition events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable |
| mode_i | input | 2 | Bit 0: 10-bit addressing; bit 1: START/STOP interrupt events |
| own_addr_i | input | 10 | Own address (7-bit mode uses bits 6:0) |
| clk_release_i | input | 1 | 0 holds SCL low, 1 releases it |
| rd_i | input | 1 | Host read strobe, clears buffer full |
| ov_clr_i | input | 1 | Clears the overflow flag |
| addr_load_i | input | 1 | Host has reloaded the address, clears update-address |
| scl_i | input | 1 | Raw SCL line |
| sda_i | input | 1 | Raw SDA line |
| scl_hold_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_low_o | output | 1 | Pull SDA low (acknowledge) |
| rx_data_o | output | 8 | Receive buffer |
| buf_full_o | output | 1 | Receive buffer holds an unread byte |
| overflow_o | output | 1 | Sticky overflow flag |
| start_seen_o | output | 1 | START was the last condition |
| stop_seen_o | output | 1 | STOP was the last condition |
| data_addr_o | output | 1 | 1 if last byte was data, 0 if address |
| rw_o | output | 1 | Direction bit of last matching address |
| upd_addr_o | output | 1 | Address register needs reloading (10-bit mode) |
| irq_o | output | 1 | One-cycle event pulse |

## Verification
A change on a bus pin reaches a status flag on the third clock edge: two synchroniser stages, then the status register. The acknowledge drive follows the same three-edge path from the SCL fall that ends the eighth bit, and it is released three edges after the fall that ends the ninth bit. The clock-stretch output follows its inputs within the same cycle, and host strobes take effect at the next edge. The bench holds every bus phase for five cycles and samples on falling clock edges, so each result is read after it has settled and before the next pin change.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned ADDR_W       = 10;
  localparam int unsigned MODE_W       = 2;
  localparam int unsigned MODE_TEN_BIT = 0;
  localparam int unsigned MODE_EVT     = 1;
  localparam logic [4:0]  TEN_TAG      = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR2,
    ST_WRITE,
    ST_READ
  } state_e;
endpackage

// File: rtl/i2cst_sync.sv
module i2cst_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;  // idle bus is high
      else         pipe_q <= {pipe_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/i2cst_cond.sv
module i2cst_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/i2cst_bitctr.sv
module i2cst_bitctr #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              scl_rise_i,
  input  logic              sda_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ack_slot_o,
  output logic              ninth_rise_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (scl_rise_i) begin
      if (cnt_q == CNT_W'(BYTE_W)) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= {sh_q[BYTE_W-3:0], sda_i};
      end
    end
  end

  assign byte_o       = {sh_q, sda_i};
  assign byte_done_o  = scl_rise_i & ~clear_i & (cnt_q == CNT_W'(BYTE_W - 1));
  assign ack_slot_o   = (cnt_q == CNT_W'(BYTE_W));
  assign ninth_rise_o = scl_rise_i & ~clear_i & ack_slot_o;
endmodule

// File: rtl/i2c_slave_status.sv
module i2c_slave_status
  import i2cst_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              clk_release_i,
  input  logic              rd_i,
  input  logic              ov_clr_i,
  input  logic              addr_load_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_hold_low_o,
  output logic              sda_low_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              buf_full_o,
  output logic              overflow_o,
  output logic              start_seen_o,
  output logic              stop_seen_o,
  output logic              data_addr_o,
  output logic              rw_o,
  output logic              upd_addr_o,
  output logic              irq_o
);
  logic [1:0] sync_q;
  logic scl_s, sda_s;
  logic start_det, stop_det, scl_rise, scl_fall;
  logic byte_done, ack_slot, ninth_rise;
  logic [BYTE_W-1:0] byte_w;

  i2cst_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o(sync_q)
  );
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  i2cst_cond u_cond (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .start_o(start_det), .stop_o(stop_det),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  i2cst_bitctr #(.BYTE_W(BYTE_W)) u_bits (
    .clk_i, .rst_ni,
    .clear_i(start_det | stop_det | ~en_i),
    .scl_rise_i(scl_rise), .sda_i(sda_s),
    .byte_done_o(byte_done), .byte_o(byte_w),
    .ack_slot_o(ack_slot), .ninth_rise_o(ninth_rise)
  );

  state_e state_q, nxt_state;
  logic ten_full_q, ack_pend_q;
  logic ten_bit, evt_irq;
  logic hit, hit_first, is_data, set_ua, reading, do_load, do_ovf, do_ack;
  logic addr7_hit, hi_hit, lo_hit;

  assign ten_bit   = mode_i[MODE_TEN_BIT];
  assign evt_irq   = mode_i[MODE_EVT];
  assign addr7_hit = byte_w[BYTE_W-1:1] == own_addr_i[6:0];
  assign hi_hit    = (byte_w[7:3] == TEN_TAG) && (byte_w[2:1] == own_addr_i[9:8]);
  assign lo_hit    = byte_w == own_addr_i[7:0];

  // byte decision, evaluated on the rising edge that completes a byte
  always_comb begin
    hit       = 1'b0;
    is_data   = 1'b0;
    set_ua    = 1'b0;
    nxt_state = ST_IDLE;
    unique case (state_q)
      ST_ADDR: begin
        if (!ten_bit && addr7_hit) begin
          hit = 1'b1;
          nxt_state = byte_w[0] ? ST_READ : ST_WRITE;
        end else if (ten_bit && hi_hit && !byte_w[0]) begin
          hit = 1'b1; set_ua = 1'b1; nxt_state = ST_ADDR2;
        end else if (ten_bit && hi_hit && byte_w[0] && ten_full_q) begin
          hit = 1'b1; nxt_state = ST_READ;
        end
      end
      ST_ADDR2: if (lo_hit) begin
        hit = 1'b1; set_ua = 1'b1; nxt_state = ST_WRITE;
      end
      ST_WRITE: begin hit = 1'b1; is_data = 1'b1; nxt_state = ST_WRITE; end
      ST_READ:  nxt_state = ST_READ;
      default:  nxt_state = ST_IDLE;
    endcase
  end

  assign hit_first = hit && (state_q == ST_ADDR);
  assign reading   = (state_q == ST_READ) || (nxt_state == ST_READ);
  assign do_load   = byte_done && hit && !buf_full_o;
  assign do_ovf    = byte_done && hit && buf_full_o && !reading;
  assign do_ack    = hit && (!is_data || !buf_full_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      ten_full_q   <= 1'b0;
      ack_pend_q   <= 1'b0;
      sda_low_o    <= 1'b0;
      rx_data_o    <= '0;
      buf_full_o   <= 1'b0;
      overflow_o   <= 1'b0;
      start_seen_o <= 1'b0;
      stop_seen_o  <= 1'b0;
      data_addr_o  <= 1'b0;
      rw_o         <= 1'b0;
      upd_addr_o   <= 1'b0;
      irq_o        <= 1'b0;
    end else if (!en_i) begin
      state_q      <= ST_IDLE;
      ten_full_q   <= 1'b0;
      ack_pend_q   <= 1'b0;
      sda_low_o    <= 1'b0;
      start_seen_o <= 1'b0;
      stop_seen_o  <= 1'b0;
      rw_o         <= 1'b0;
      upd_addr_o   <= 1'b0;
      irq_o        <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (rd_i)        buf_full_o <= 1'b0;
      if (ov_clr_i)    overflow_o <= 1'b0;
      if (addr_load_i) upd_addr_o <= 1'b0;
      if (start_det) begin
        start_seen_o <= 1'b1;
        stop_seen_o  <= 1'b0;
        rw_o         <= 1'b0;
        state_q      <= ST_ADDR;
        sda_low_o    <= 1'b0;
        ack_pend_q   <= 1'b0;
        irq_o        <= evt_irq;
      end else if (stop_det) begin
        stop_seen_o  <= 1'b1;
        start_seen_o <= 1'b0;
        rw_o         <= 1'b0;
        ten_full_q   <= 1'b0;
        state_q      <= ST_IDLE;
        sda_low_o    <= 1'b0;
        ack_pend_q   <= 1'b0;
        irq_o        <= evt_irq;
      end else begin
        if (scl_fall && ack_slot && ack_pend_q) begin
          sda_low_o  <= 1'b1;
          ack_pend_q <= 1'b0;
        end else if (scl_fall && !ack_slot) begin
          sda_low_o  <= 1'b0;
        end
        // master leaves SDA high in the ninth clock of a read byte
        if (ninth_rise && state_q == ST_READ && sda_s) begin
          rw_o    <= 1'b0;
          state_q <= ST_IDLE;
        end
        if (byte_done) begin
          state_q    <= nxt_state;
          ack_pend_q <= do_ack;
          if (hit_first)   rw_o        <= byte_w[0];
          if (hit)         data_addr_o <= is_data;
          if (set_ua)      upd_addr_o  <= 1'b1;
          if (state_q == ST_ADDR2) ten_full_q <= lo_hit;
          if (do_load) begin
            rx_data_o  <= byte_w;
            buf_full_o <= 1'b1;
            irq_o      <= 1'b1;
          end
          if (do_ovf) begin
            overflow_o <= 1'b1;
            irq_o      <= 1'b1;
          end
        end
      end
    end
  end

  assign scl_hold_low_o = en_i & ~clk_release_i;

  a_r1_start_stop_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_seen_o && stop_seen_o));
  a_r1_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!start_seen_o && !stop_seen_o));
  a_r2_ack_in_transfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> (state_q != ST_IDLE && state_q != ST_ADDR));
  a_r3_full_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_load |=> buf_full_o);
  a_r4_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !ov_clr_i) |=> overflow_o);
  a_r7_rw_clear_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && stop_det) |=> !rw_o);
  a_r8_ua_only_ten_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(upd_addr_o) |-> $past(ten_bit));
endmodule

// File: tb/tb_i2c_slave_status.sv
module tb_i2c_slave_status;
  localparam int Q = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [9:0] own_addr_i = 10'h05A;
  logic clk_release_i = 1'b1;
  logic rd_i = 1'b0, ov_clr_i = 1'b0, addr_load_i = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic scl_hold_low_o, sda_low_o, buf_full_o, overflow_o;
  logic start_seen_o, stop_seen_o, data_addr_o, rw_o, upd_addr_o, irq_o;
  logic [7:0] rx_data_o;

  int checks = 0;
  int fails = 0;
  int irq_cnt = 0;

  always #5 clk_i = ~clk_i;

  assign sda_line = sda_m & ~sda_low_o;

  i2c_slave_status dut (
    .clk_i, .rst_ni, .en_i, .mode_i, .own_addr_i, .clk_release_i,
    .rd_i, .ov_clr_i, .addr_load_i,
    .scl_i(scl_m), .sda_i(sda_line),
    .scl_hold_low_o, .sda_low_o, .rx_data_o, .buf_full_o, .overflow_o,
    .start_seen_o, .stop_seen_o, .data_addr_o, .rw_o, .upd_addr_o, .irq_o
  );

  always @(posedge clk_i) if (irq_o) irq_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic phase();
    repeat (Q) @(negedge clk_i);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk_i); s = 1'b1;
    @(negedge clk_i); s = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; phase();
    scl_m = 1'b1; phase();
    sda_m = 1'b0; phase();
    scl_m = 1'b0; phase();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; phase();
    scl_m = 1'b1; phase();
    sda_m = 1'b1; phase();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic ninth, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; phase();
      scl_m = 1'b1; phase();
      scl_m = 1'b0; phase();
    end
    sda_m = ninth; phase();
    scl_m = 1'b1; phase();
    acked = ~sda_line;
    scl_m = 1'b0; phase();
  endtask

  initial begin
    logic ack;
    int base;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 R3 R4 R9 reset state
    chk("R1 reset start", start_seen_o, 0);
    chk("R1 reset stop", stop_seen_o, 0);
    chk("R3 reset full", buf_full_o, 0);
    chk("R4 reset ovf", overflow_o, 0);
    chk("R7 reset rw", rw_o, 0);
    chk("R8 reset ua", upd_addr_o, 0);
    chk("R2 reset ack", sda_low_o, 0);
    chk("R9 reset hold", scl_hold_low_o, 0);
    en_i = 1'b1;
    phase();

    // R9 clock stretch
    clk_release_i = 1'b0; @(negedge clk_i);
    chk("R9 hold", scl_hold_low_o, 1);
    clk_release_i = 1'b1; @(negedge clk_i);
    chk("R9 release", scl_hold_low_o, 0);

    // R2 sweep all 7-bit addresses, R1 R3 R6 on the match
    for (int a = 0; a < 128; a++) begin
      bus_start();
      chk("R1 start seen", {start_seen_o, stop_seen_o}, 2'b10);
      send_byte({a[6:0], 1'b0}, 1'b1, ack);
      chk("R2 addr ack", ack, (a == 'h5A));
      if (a == 'h5A) begin
        chk("R3 addr loaded", {buf_full_o, rx_data_o}, {1'b1, 8'hB4});
        chk("R6 addr flag", data_addr_o, 0);
        pulse(rd_i);
        chk("R3 read clears", buf_full_o, 0);
      end
      send_byte(8'hC3, 1'b1, ack);
      chk("R2 data ack", ack, (a == 'h5A));
      if (a == 'h5A) begin
        chk("R3 data loaded", {buf_full_o, rx_data_o}, {1'b1, 8'hC3});
        chk("R6 data flag", data_addr_o, 1);
        pulse(rd_i);
      end else begin
        chk("R2 ignored", buf_full_o, 0);
      end
      bus_stop();
      chk("R1 stop seen", {start_seen_o, stop_seen_o}, 2'b01);
    end

    // R4 overflow
    bus_start();
    send_byte(8'hB4, 1'b1, ack);
    pulse(rd_i);
    send_byte(8'h11, 1'b1, ack);
    send_byte(8'h22, 1'b1, ack);
    chk("R4 nack on ovf", ack, 0);
    chk("R4 ovf set", overflow_o, 1);
    chk("R4 data kept", rx_data_o, 8'h11);
    bus_stop();
    chk("R4 ovf sticky", overflow_o, 1);
    pulse(ov_clr_i);
    chk("R4 ovf cleared", overflow_o, 0);

    // R5 read address with full buffer
    bus_start();
    send_byte(8'hB5, 1'b1, ack);
    chk("R5 read ack", ack, 1);
    chk("R5 no ovf", overflow_o, 0);
    chk("R7 rw set", rw_o, 1);
    send_byte(8'hFF, 1'b1, ack);
    chk("R7 nack clears rw", rw_o, 0);
    bus_stop();
    pulse(rd_i);
    // R7 START clears rw
    bus_start();
    send_byte(8'hB5, 1'b1, ack);
    chk("R7 rw set again", rw_o, 1);
    bus_start();
    chk("R7 start clears rw", rw_o, 0);
    send_byte(8'hB5, 1'b1, ack);
    bus_stop();
    chk("R7 stop clears rw", rw_o, 0);
    pulse(rd_i);

    // R10 interrupts
    base = irq_cnt;
    bus_start();
    chk("R10 no start irq", irq_cnt - base, 0);
    bus_stop();
    chk("R10 no stop irq", irq_cnt - base, 0);
    mode_i = 2'b10;
    base = irq_cnt;
    bus_start();
    chk("R10 start irq", irq_cnt - base, 1);
    send_byte(8'hB4, 1'b1, ack);
    chk("R10 byte irq", irq_cnt - base, 2);
    bus_stop();
    chk("R10 stop irq", irq_cnt - base, 3);
    pulse(rd_i);

    // R8 10-bit addressing, own = 0x2A5 -> F4 / A5
    mode_i = 2'b01;
    own_addr_i = 10'h2A5;
    bus_start();
    send_byte(8'hF4, 1'b1, ack);
    chk("R8 hi ack", ack, 1);
    chk("R8 ua after hi", upd_addr_o, 1);
    pulse(addr_load_i);
    chk("R8 ua cleared", upd_addr_o, 0);
    pulse(rd_i);
    send_byte(8'hA5, 1'b1, ack);
    chk("R8 lo ack", ack, 1);
    chk("R8 ua after lo", upd_addr_o, 1);
    chk("R8 lo loaded", rx_data_o, 8'hA5);
    pulse(rd_i);
    pulse(addr_load_i);
    send_byte(8'h77, 1'b1, ack);
    chk("R8 data ack", ack, 1);
    chk("R6 data after 10b", {data_addr_o, rx_data_o}, {1'b1, 8'h77});
    pulse(rd_i);
    bus_start();
    send_byte(8'hF5, 1'b1, ack);
    chk("R8 hi read ack", ack, 1);
    chk("R7 rw 10b read", rw_o, 1);
    send_byte(8'hFF, 1'b1, ack);
    bus_stop();
    pulse(rd_i);
    bus_start();
    send_byte(8'hF4, 1'b1, ack);
    pulse(rd_i);
    send_byte(8'hA4, 1'b1, ack);
    chk("R8 lo mismatch nack", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hF5, 1'b1, ack);
    chk("R8 read needs full match", ack, 0);
    bus_stop();

    // R1 disable clears condition flags
    bus_start();
    chk("R1 start before disable", start_seen_o, 1);
    en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R1 disabled", {start_seen_o, stop_seen_o}, 2'b00);
    en_i = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule